// File: doc/BRIEF.md
# Sensor Synchronization Code Channel

This block produces the serial lane that runs next to the pixel data lanes of an image sensor readout and tells the receiver where frames and lines begin and end. An imaging sequencer pulses frame and line events and presents a line address. The channel turns these into one control word per word slot. A word slot is marked by a load strobe. When nothing is pending, the lane fills with two alternating idle words.

The pixel lanes reach the output later than the sequencer events, because their samples pass through front-end and conversion stages. A delay line of `DEPTH` word slots holds each chosen word back by that same number of slots, so each marker leaves beside the pixel word it describes. The delayed word is then loaded into a shifter and sent one bit per bit-clock cycle, with the same timing as the data lanes.

Top module: `sync_code_lane`

## Requirements
- R1: A synchronous reset fills every delay slot and the shifter with the IdleA word. It also clears all pending events. The first idle word chosen after reset is IdleA.
- R2: A word chosen at one load strobe is shifted out starting at the load strobe `DEPTH` strobes later (default 4). Until then, the delayed words already in flight come out first.
- R3: At a load with no pending event, the chosen word is IdleA or IdleB. The two alternate on every idle slot. Defaults: IdleA = 10'h1E3, IdleB = 10'h21C.
- R4: When several requests meet in one slot, the winner follows the order SOF, SOL, line address, EOL, idle. Each request that loses stays pending for a later slot. Defaults: SOF = 10'h2AC, SOL = 10'h2B3, EOL = 10'h2D5.
- R5: A `line_start` pulse requests an SOL word and also an address word. The address word is `line_addr`, sampled on that pulse and zero-extended to the word width. By priority, the address word follows the SOL word.
- R6: An event that arrives on a cycle without the load strobe is held. It then takes part in the next load.
- R7: The shifter captures a new word only when `load` is high. On every other cycle it shifts by one bit. The most significant bit is sent first: on the cycle after the load it sits on `sdo`, and the least significant bit follows `WORD_W-1` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Word-slot strobe, high one cycle in every `WORD_W` |
| frame_start | input | 1 | Request for a start-of-frame word |
| line_start | input | 1 | Request for a start-of-line word and an address word |
| line_end | input | 1 | Request for an end-of-line word |
| line_addr | input | ADDR_W | Line address, sampled with `line_start` |
| sdo | output | 1 | Serial code output |

## Verification
A word-slot decision can meet more than one request in the same cycle. Examples are SOF with SOL, SOF with EOL, and SOL with EOL while an address word is still owed. The bench provokes this by pulsing several event inputs on one load cycle. It then checks, after the delay line, that the winners come out in priority order over the following slots and that no losing request is lost. Events arriving between strobes are applied separately to show that they are held until the next slot.

// File: rtl/sync_code_lane.sv
module sync_code_lane #(
  parameter int          WORD_W    = 10,
  parameter int          ADDR_W    = 8,
  parameter int          DEPTH     = 4,
  parameter bit          MSB_FIRST = 1'b1,
  parameter logic [9:0]  SOF_CODE  = 10'h2AC,
  parameter logic [9:0]  SOL_CODE  = 10'h2B3,
  parameter logic [9:0]  EOL_CODE  = 10'h2D5,
  parameter logic [9:0]  IDLE_A    = 10'h1E3,
  parameter logic [9:0]  IDLE_B    = 10'h21C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              line_end,
  input  logic [ADDR_W-1:0] line_addr,
  output logic              sdo
);

  localparam logic [WORD_W-1:0] W_SOF   = WORD_W'(SOF_CODE);
  localparam logic [WORD_W-1:0] W_SOL   = WORD_W'(SOL_CODE);
  localparam logic [WORD_W-1:0] W_EOL   = WORD_W'(EOL_CODE);
  localparam logic [WORD_W-1:0] W_IDLEA = WORD_W'(IDLE_A);
  localparam logic [WORD_W-1:0] W_IDLEB = WORD_W'(IDLE_B);

  typedef enum logic [2:0] {K_SOF, K_SOL, K_ADR, K_EOL, K_IDLE} kind_t;

  logic              sof_p, sol_p, adr_p, eol_p, idle_b;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] dly_q [DEPTH];
  logic [WORD_W-1:0] sh_q;
  kind_t             kind;
  logic [WORD_W-1:0] word_sel;

  wire              sof_any  = sof_p | frame_start;
  wire              sol_any  = sol_p | line_start;
  wire              adr_any  = adr_p | line_start;
  wire              eol_any  = eol_p | line_end;
  wire              any_req  = sof_any | sol_any | adr_any | eol_any;
  wire [ADDR_W-1:0] addr_cur = line_start ? line_addr : addr_q;

  always_comb begin
    if (sof_any)      kind = K_SOF;
    else if (sol_any) kind = K_SOL;
    else if (adr_any) kind = K_ADR;
    else if (eol_any) kind = K_EOL;
    else              kind = K_IDLE;
  end

  always_comb begin
    case (kind)
      K_SOF:   word_sel = W_SOF;
      K_SOL:   word_sel = W_SOL;
      K_ADR:   word_sel = WORD_W'(addr_cur);
      K_EOL:   word_sel = W_EOL;
      default: word_sel = idle_b ? W_IDLEB : W_IDLEA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sof_p  <= 1'b0;
      sol_p  <= 1'b0;
      adr_p  <= 1'b0;
      eol_p  <= 1'b0;
      idle_b <= 1'b0;
      addr_q <= '0;
    end else begin
      sof_p  <= sof_any & ~(load && kind == K_SOF);
      sol_p  <= sol_any & ~(load && kind == K_SOL);
      adr_p  <= adr_any & ~(load && kind == K_ADR);
      eol_p  <= eol_any & ~(load && kind == K_EOL);
      addr_q <= addr_cur;
      if (load && kind == K_IDLE) idle_b <= ~idle_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) dly_q[i] <= W_IDLEA;
    end else if (load) begin
      dly_q[0] <= word_sel;
      for (int i = 1; i < DEPTH; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  generate
    if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk) begin
        if (rst)       sh_q <= W_IDLEA;
        else if (load) sh_q <= dly_q[DEPTH-1];
        else           sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      end
      assign sdo = sh_q[WORD_W-1];
    end else begin : g_lsb
      always_ff @(posedge clk) begin
        if (rst)       sh_q <= W_IDLEA;
        else if (load) sh_q <= dly_q[DEPTH-1];
        else           sh_q <= {1'b0, sh_q[WORD_W-1:1]};
      end
      assign sdo = sh_q[0];
    end
  endgenerate

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (dly_q[DEPTH-1] == W_IDLEA && !idle_b && !sof_p && !eol_p)); // R1
  AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dly_q[0])); // R2
  AST_IDLE_A_TURN: assert property (@(posedge clk) disable iff (rst)
    (load && !any_req && !idle_b) |=> (dly_q[0] == W_IDLEA && idle_b)); // R3
  AST_IDLE_B_TURN: assert property (@(posedge clk) disable iff (rst)
    (load && !any_req && idle_b) |=> (dly_q[0] == W_IDLEB && !idle_b)); // R3
  AST_SOF_WINS: assert property (@(posedge clk) disable iff (rst)
    (load && sof_any) |=> dly_q[0] == W_SOF); // R4
  AST_SOL_OVER_EOL: assert property (@(posedge clk) disable iff (rst)
    (load && !sof_any && sol_any && eol_any) |=> (dly_q[0] == W_SOL && eol_p)); // R4
  AST_ADDR_OWED: assert property (@(posedge clk) disable iff (rst)
    (load && !sof_any && line_start) |=> adr_p); // R5
  AST_HOLD_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!load && line_end) |=> eol_p); // R6
  AST_LOAD_BIT: assert property (@(posedge clk) disable iff (rst)
    load |=> sdo == $past(MSB_FIRST ? dly_q[DEPTH-1][WORD_W-1] : dly_q[DEPTH-1][0])); // R7

endmodule

// File: tb/tb_sync_code_lane.sv
module tb_sync_code_lane;
  localparam int W = 10;
  localparam int D = 4;
  localparam logic [9:0] SOF = 10'h2AC, SOL = 10'h2B3, EOL = 10'h2D5;
  localparam logic [9:0] IA = 10'h1E3, IB = 10'h21C;
  localparam int NV = 18;

  logic clk = 1'b0, rst = 1'b1, load = 1'b0;
  logic frame_start = 1'b0, line_start = 1'b0, line_end = 1'b0;
  logic [7:0] line_addr = '0;
  logic sdo;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_code_lane dut (.clk(clk), .rst(rst), .load(load), .frame_start(frame_start),
    .line_start(line_start), .line_end(line_end), .line_addr(line_addr), .sdo(sdo));

  // {sof, sol, eol, addr[7:0], expected chosen word[9:0]}
  localparam logic [20:0] VEC [NV] = '{
    {3'b000, 8'h00, IA},
    {3'b000, 8'h00, IB},
    {3'b010, 8'h12, SOL},
    {3'b000, 8'h00, 10'h012},
    {3'b001, 8'h00, EOL},
    {3'b000, 8'h00, IA},
    {3'b110, 8'h34, SOF},
    {3'b001, 8'h00, SOL},
    {3'b000, 8'h00, 10'h034},
    {3'b000, 8'h00, EOL},
    {3'b000, 8'h00, IB},
    {3'b101, 8'h00, SOF},
    {3'b000, 8'h00, EOL},
    {3'b000, 8'h00, IA},
    {3'b000, 8'h00, IB},
    {3'b000, 8'h00, IA},
    {3'b000, 8'h00, IB},
    {3'b000, 8'h00, IA}
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; load = 1'b0;
    frame_start = 1'b0; line_start = 1'b0; line_end = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic slot(input logic [2:0] ev, input logic [7:0] a, input int at,
                      output logic [9:0] w);
    for (int j = 0; j < W; j++) begin
      if (j == 0) load = 1'b1;
      if (j == at) begin
        frame_start = ev[2]; line_start = ev[1]; line_end = ev[0]; line_addr = a;
      end
      @(posedge clk);
      @(negedge clk);
      load = 1'b0; frame_start = 1'b0; line_start = 1'b0; line_end = 1'b0;
      w[W-1-j] = sdo;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] w;
    do_reset();
    check("R1 reset sdo", {9'd0, sdo}, {9'd0, IA[9]});
    // main table: received word at slot s is the word chosen DEPTH slots earlier (R2, R3, R4, R5, R7)
    for (int s = 0; s < NV + D; s++) begin
      if (s < NV) slot(VEC[s][20:18], VEC[s][17:10], 0, w);
      else        slot(3'b000, 8'h00, 0, w);
      if (s < D) check("R1 R2 reset fill", w, IA);
      else       check("R2 R3 R4 R5 R7 table word", w, VEC[s-D][9:0]);
    end
    // R6: an event between strobes waits for the next slot; R1: alternation restarts at IdleA
    do_reset();
    for (int s = 0; s < D + 3; s++) begin
      if (s == 0) slot(3'b001, 8'h00, 3, w);
      else        slot(3'b000, 8'h00, 0, w);
      if (s == D)     check("R1 first idle after reset", w, IA);
      if (s == D + 1) check("R6 held line_end", w, EOL);
      if (s == D + 2) check("R3 idle after held event", w, IB);
    end
    // R4 with R5: SOL and EOL together, then SOF arriving mid-slot while address still owed
    do_reset();
    for (int s = 0; s < D + 4; s++) begin
      if (s == 0)      slot(3'b011, 8'hA5, 0, w);
      else if (s == 1) slot(3'b100, 8'h00, 4, w);
      else             slot(3'b000, 8'h00, 0, w);
      if (s == D)     check("R4 SOL beats EOL", w, SOL);
      if (s == D + 1) check("R4 address beats EOL", w, 10'h0A5);
      if (s == D + 2) check("R4 R6 held SOF beats EOL", w, SOF);
      if (s == D + 3) check("R4 EOL finally sent", w, EOL);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule